// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block decides, for each of the two ALU operands of an in-order five-stage integer pipeline, where the operand value should come from. It looks at the two source register numbers of the instruction now in the execute stage. It compares them with the destination register and write flag of the instruction one stage ahead (memory stage) and of the instruction two stages ahead (writeback stage). For each operand it returns a 2-bit select that steers an external multiplexer. The multiplexer picks the register-file read, the memory-stage ALU result, or the writeback value.

The logic is purely combinational. It has no clock and no state, so a select settles in the same cycle as the indices that produce it. The ALU, the multiplexers, the register file and any stall logic sit outside the block.

Top module: `fwd_unit`

## Requirements
- R1: When the memory-stage write flag is 1, its destination is nonzero, and it equals an operand's source index, that operand's select is 2'b10, which picks the memory-stage ALU result.
- R2: When the writeback-stage write flag is 1, its destination is nonzero, it equals an operand's source index, and R1 does not apply to that operand, the select is 2'b01, which picks the writeback value.
- R3: When both later stages qualify for the same operand under R1 and R2, the memory-stage (younger) result wins and the select is 2'b10.
- R4: A source index of zero always yields select 2'b00, because register zero is constant zero and is never forwarded, whatever the later stages write.
- R5: When no forwarding condition holds, the select is 2'b00, which picks the register-file read. A matching destination whose write flag is 0 has no effect on the select.
- R6: Operand A and operand B are decided by identical, independent logic. Each select depends only on its own source index and on the shared stage fields.
- R7: The selects are combinational and follow input changes within the same cycle, with no clock or register on the path.
- R8: The code 2'b11 never appears on either select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | 5 | Execute-stage source register index for operand A |
| ex_src_b | input | 5 | Execute-stage source register index for operand B |
| mem_dst | input | 5 | Memory-stage destination register index |
| mem_wr | input | 1 | Memory-stage register write flag |
| wb_dst | input | 5 | Writeback-stage destination register index |
| wb_wr | input | 1 | Writeback-stage register write flag |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |

## Verification
Each select is due zero cycles after its inputs change, because no register lies between the ports. The bench drives a new input set on the falling clock edge and compares both selects with its behavioural model on the following rising edge, by which point the outputs have long settled. For the same-cycle requirement, a few directed cases are also checked one nanosecond after the inputs are driven, well inside the half period.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    // Operand source select codes
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,   // register-file read
        SEL_WB  = 2'b01,   // writeback-stage value
        SEL_EXM = 2'b10    // memory-stage ALU result
    } fwd_sel_e;

    // Hit flags for one operand
    typedef struct packed {
        logic exm;
        logic wb;
    } fwd_hits_t;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
    parameter int IDX_W = 5
) (
    input  logic             wr_en,
    input  logic [IDX_W-1:0] dst,
    input  logic [IDX_W-1:0] src,
    output logic             hit
);

    logic dst_live;

    always_comb begin
        dst_live = wr_en && (dst != '0);
        hit      = dst_live && (dst == src);
    end

endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
    import fwd_pkg::*;
(
    input  fwd_hits_t   hits,
    output logic [1:0]  sel
);

    fwd_sel_e sel_d;

    always_comb begin
        sel_d = SEL_RF;
        if (hits.exm) begin
            sel_d = SEL_EXM;
        end else if (hits.wb) begin
            sel_d = SEL_WB;
        end
        sel = sel_d;
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic [IDX_W-1:0] ex_src_a,
    input  logic [IDX_W-1:0] ex_src_b,
    input  logic [IDX_W-1:0] mem_dst,
    input  logic             mem_wr,
    input  logic [IDX_W-1:0] wb_dst,
    input  logic             wb_wr,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b
);

    localparam int NUM_OPS = 2;

    logic [IDX_W-1:0] src_vec [NUM_OPS];
    logic [1:0]       sel_vec [NUM_OPS];

    assign src_vec[0] = ex_src_a;
    assign src_vec[1] = ex_src_b;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        fwd_hits_t hits;

        fwd_hit #(.IDX_W(IDX_W)) u_exm_hit (
            .wr_en (mem_wr),
            .dst   (mem_dst),
            .src   (src_vec[g]),
            .hit   (hits.exm)
        );

        fwd_hit #(.IDX_W(IDX_W)) u_wb_hit (
            .wr_en (wb_wr),
            .dst   (wb_dst),
            .src   (src_vec[g]),
            .hit   (hits.wb)
        );

        fwd_pick u_pick (
            .hits (hits),
            .sel  (sel_vec[g])
        );
    end

    assign sel_a = sel_vec[0];
    assign sel_b = sel_vec[1];

endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
    parameter int IDX_W = 5
) (
    input logic [IDX_W-1:0] ex_src_a,
    input logic [IDX_W-1:0] ex_src_b,
    input logic [IDX_W-1:0] mem_dst,
    input logic             mem_wr,
    input logic [IDX_W-1:0] wb_dst,
    input logic             wb_wr,
    input logic [1:0]       sel_a,
    input logic [1:0]       sel_b
);

    logic exm_a, exm_b, wb_a, wb_b;

    always_comb begin
        exm_a = mem_wr && (mem_dst != '0) && (mem_dst == ex_src_a);
        exm_b = mem_wr && (mem_dst != '0) && (mem_dst == ex_src_b);
        wb_a  = wb_wr  && (wb_dst  != '0) && (wb_dst  == ex_src_a);
        wb_b  = wb_wr  && (wb_dst  != '0) && (wb_dst  == ex_src_b);
    end

    always_comb begin
        p_exm_fwd_r1 : assert (!(exm_a && !wb_a) || sel_a == 2'b10);
        p_wb_fwd_r2  : assert (!(wb_a && !exm_a) || sel_a == 2'b01);
        p_younger_r3 : assert (!(exm_a && wb_a) || sel_a == 2'b10);
        p_zero_r4    : assert (ex_src_a != '0 || sel_a == 2'b00);
        p_default_r5 : assert (exm_a || wb_a || sel_a == 2'b00);
        p_b_exm_r6   : assert (!exm_b || sel_b == 2'b10);
        p_b_wb_r6    : assert (!(wb_b && !exm_b) || sel_b == 2'b01);
        p_b_none_r6  : assert (exm_b || wb_b || sel_b == 2'b00);
        p_no_code3_r8: assert (sel_a != 2'b11 && sel_b != 2'b11);
    end

endmodule

bind fwd_unit fwd_unit_chk #(.IDX_W(IDX_W)) u_fwd_unit_chk (
    .ex_src_a (ex_src_a),
    .ex_src_b (ex_src_b),
    .mem_dst  (mem_dst),
    .mem_wr   (mem_wr),
    .wb_dst   (wb_dst),
    .wb_wr    (wb_wr),
    .sel_a    (sel_a),
    .sel_b    (sel_b)
);

// File: tb/fwd_unit_bench.sv
`timescale 1ns/1ps
module fwd_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [4:0] ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
    logic       mem_wr = 1'b0, wb_wr = 1'b0;
    logic [1:0] sel_a, sel_b;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fwd_unit u_fwd_unit (
        .ex_src_a (ex_src_a),
        .ex_src_b (ex_src_b),
        .mem_dst  (mem_dst),
        .mem_wr   (mem_wr),
        .wb_dst   (wb_dst),
        .wb_wr    (wb_wr),
        .sel_a    (sel_a),
        .sel_b    (sel_b)
    );

    // Behavioural reference: 2 = memory stage, 1 = writeback, 0 = register file
    function automatic int ref_sel(int src);
        if (mem_wr && mem_dst != 0 && int'(mem_dst) == src) return 2;
        if (wb_wr && wb_dst != 0 && int'(wb_dst) == src) return 1;
        return 0;
    endfunction

    function automatic string req_of(int src);
        bit e, w;
        e = mem_wr && mem_dst != 0 && int'(mem_dst) == src;
        w = wb_wr && wb_dst != 0 && int'(wb_dst) == src;
        if (src == 0) return "R4";
        if (e && w)   return "R3";
        if (e)        return "R1";
        if (w)        return "R2";
        return "R5";
    endfunction

    task automatic check_pair(string extra);
        int ea, eb;
        ea = ref_sel(int'(ex_src_a));
        eb = ref_sel(int'(ex_src_b));
        total++;
        if (int'(sel_a) != ea || sel_a == 2'b11) begin
            bad++;
            $display("FAIL %s%s opA: actual=%0d expected=%0d", req_of(int'(ex_src_a)), extra, sel_a, ea);
        end
        total++;
        if (int'(sel_b) != eb || sel_b == 2'b11) begin
            bad++;
            $display("FAIL %s/R6%s opB: actual=%0d expected=%0d", req_of(int'(ex_src_b)), extra, sel_b, eb);
        end
    endtask

    // Drive on the falling edge, check at the next rising edge
    task automatic apply(input logic [4:0] a, input logic [4:0] b,
                         input logic [4:0] md, input logic mw,
                         input logic [4:0] wd, input logic ww);
        @(negedge clk);
        ex_src_a = a; ex_src_b = b;
        mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
        @(posedge clk);
        #0.5;
        check_pair("");
    endtask

    // Same-cycle response check for R7
    task automatic apply_now(input logic [4:0] a, input logic [4:0] b,
                             input logic [4:0] md, input logic mw,
                             input logic [4:0] wd, input logic ww);
        @(negedge clk);
        ex_src_a = a; ex_src_b = b;
        mem_dst = md; mem_wr = mw; wb_dst = wd; wb_wr = ww;
        #1;
        check_pair(" R7");
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        #0.5;
        check_pair(" reset");                      // all-zero inputs -> 00
        apply(5'd3, 5'd4, 5'd3, 1, 5'd9, 1);      // R1 on A
        apply(5'd3, 5'd4, 5'd8, 1, 5'd4, 1);      // R2 on B
        apply(5'd7, 5'd7, 5'd7, 1, 5'd7, 1);      // R3 both
        apply(5'd0, 5'd0, 5'd0, 1, 5'd0, 1);      // R4 zero dest
        apply(5'd0, 5'd2, 5'd0, 1, 5'd2, 0);      // R4 and R5 (wb flag off)
        apply(5'd6, 5'd6, 5'd6, 0, 5'd6, 0);      // R5 flags off
        apply(5'd6, 5'd6, 5'd6, 0, 5'd6, 1);      // R2 when memory flag off
        apply(5'd12, 5'd13, 5'd13, 1, 5'd12, 1);  // R6 independent
        apply(5'd31, 5'd1, 5'd31, 1, 5'd1, 1);    // top index
        apply(5'd5, 5'd9, 5'd1, 1, 5'd2, 1);      // R5 no match
        apply_now(5'd10, 5'd11, 5'd10, 1, 5'd11, 1);
        apply_now(5'd10, 5'd11, 5'd11, 1, 5'd10, 1);
        apply_now(5'd0, 5'd11, 5'd0, 1, 5'd0, 1);
        for (int i = 0; i < 3000; i++) begin
            apply(5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 1'($urandom),
                  5'($urandom_range(0, 3)), 1'($urandom));
        end
        for (int i = 0; i < 500; i++) begin
            apply(5'($urandom), 5'($urandom), 5'($urandom), 1'($urandom),
                  5'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule